// File: doc/BRIEF.md
# Trigger-Level Sample FIFO with Channel Scan

This block is a sixteen-entry circular store placed between the result stream of a multi-channel converter and the read port of a processor. Every conversion result arrives with a strobe, a 10-bit sample and a 2-bit channel tag. The block accepts a result only when its tag matches the channel expected next in a fixed round-robin scan. A stored word's position therefore also tells which channel it came from. The processor pops words one at a time with a read strobe.

A programmable batch size controls the data-available output. That output rises once the number of unread words reaches the batch size, so it can serve as an interrupt. On each interrupt the processor drains one batch. When the batch size is a multiple of the scanned channel count, every batch begins with channel 0.

A synchronous flush input empties the store and clears its flags. A write into a full store sets a sticky overflow flag, and a read of an empty store sets a sticky underflow flag.

Top module: `scan_batch_fifo`

## Requirements
- R1: After reset, dataAvail, overflow and underflow are 0, the store is empty, rdData and rdTag are 0, and the next expected channel is 0.
- R2: Words come out of rdData and rdTag in the order they were accepted, across pointer wrap-around, with up to 16 unread words held. Each popped word appears on the outputs in the cycle after the clock edge that samples rdEn.
- R3: A write with a matching tag while 16 words are unread is discarded. It leaves the stored words untouched and sets overflow, which stays set until a flush.
- R4: A read while the store is empty leaves rdData and rdTag unchanged. It sets underflow, which stays set until a flush. Without an accepted read, rdData and rdTag hold their values.
- R5: dataAvail is 1 exactly when the unread count is at least the batch size. The batch size is selected by cfgLevel: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 8, code 4 gives 12, and codes 5, 6 and 7 give 16. A change of cfgLevel takes effect at once.
- R6: dataAvail falls as soon as reads take the unread count below the batch size. It rises again when later writes bring the count back up to the batch size.
- R7: cfgChans holds the number of scanned channels minus one. The expected channel starts at 0, advances by one on each accepted write and returns to 0 after the value cfgChans. A write whose wrTag differs from the expected channel is discarded without setting any flag.
- R8: A cycle with cfgFlush high empties the store, clears overflow and underflow and sets the expected channel to 0. A write or read in that same cycle is ignored, and rdData keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Conversion result strobe |
| wrData | input | 10 | Conversion sample |
| wrTag | input | 2 | Channel of the conversion sample |
| rdEn | input | 1 | Processor pop strobe |
| rdData | output | 10 | Sample of the last popped word |
| rdTag | output | 2 | Channel of the last popped word |
| cfgLevel | input | 3 | Batch size code |
| cfgChans | input | 2 | Scanned channels minus one |
| cfgFlush | input | 1 | Synchronous store flush |
| dataAvail | output | 1 | Batch ready, usable as interrupt |
| overflow | output | 1 | Sticky write-when-full flag |
| underflow | output | 1 | Sticky read-when-empty flag |

## Verification
If the read pointer or the unread count drifts, it shows on the very next pop: rdData or rdTag carries a word out of order, or a word that was never written. The same drift moves the dataAvail edge by one write away from the batch size, which is seen on the same cycle. If the scan position is wrong, a correctly tagged result is discarded. That shows as a missing dataAvail rise and a shifted channel sequence within one scan round. If the sticky flags are wrong, the fault appears in the cycle after the first write into a full store or the first read of an empty one.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  // Strobes issued by the control toward the storage datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrobe_t;

  // Batch size in words for a 3-bit level code, limited to the store depth.
  function automatic int levelFromCode(input logic [2:0] code, input int depth);
    int size;
    case (code)
      3'd0: size = 1;
      3'd1: size = 2;
      3'd2: size = 4;
      3'd3: size = 8;
      3'd4: size = 12;
      default: size = 16;
    endcase
    if (size > depth) size = depth;
    return size;
  endfunction

endpackage

// File: rtl/sbf_ctrl.sv
module sbf_ctrl
  import sbf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TAG_W = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [TAG_W-1:0] wrTag,
  input  logic             rdEn,
  input  logic [2:0]       cfgLevel,
  input  logic [TAG_W-1:0] cfgChans,
  input  logic             cfgFlush,
  output fifoStrobe_t      strobe,
  output logic [CNT_W-1:0] countQ,
  output logic             dataAvail,
  output logic             overflow,
  output logic             underflow
);

  logic             full;
  logic             empty;
  logic             tagMatch;
  logic [TAG_W-1:0] scanPos;
  logic [CNT_W-1:0] levelNeed;

  assign full     = (countQ == CNT_W'(DEPTH));
  assign empty    = (countQ == '0);
  assign tagMatch = (wrTag == scanPos);

  always_comb begin
    strobe.flush = cfgFlush;
    strobe.push  = wrEn && tagMatch && !full && !cfgFlush;
    strobe.pop   = rdEn && !empty && !cfgFlush;
  end

  always_comb levelNeed = CNT_W'(levelFromCode(cfgLevel, DEPTH));
  assign dataAvail = (countQ >= levelNeed);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ    <= '0;
      scanPos   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (cfgFlush) begin
      countQ    <= '0;
      scanPos   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
      if (strobe.push) scanPos <= (scanPos == cfgChans) ? '0 : scanPos + 1'b1;
      if (wrEn && tagMatch && full) overflow <= 1'b1;
      if (rdEn && empty) underflow <= 1'b1;
    end
  end

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(DEPTH)); // R2
  AST_FULL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && tagMatch && full && !cfgFlush) |=> (overflow && countQ == CNT_W'(DEPTH) - CNT_W'($past(rdEn)))); // R3
  AST_EMPTY_READ_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && empty && !cfgFlush) |=> underflow); // R4
  AST_WRONG_TAG_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !tagMatch && !rdEn && !cfgFlush) |=> $stable(countQ)); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cfgFlush |=> (countQ == '0 && !overflow && !underflow && scanPos == '0)); // R8

endmodule

// File: rtl/sbf_datapath.sv
module sbf_datapath
  import sbf_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int TAG_W  = 2,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int WORD_W = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [TAG_W-1:0]  wrTag,
  output logic [DATA_W-1:0] rdData,
  output logic [TAG_W-1:0]  rdTag,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr
);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [WORD_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrSlot;

  // Write pointer names the last written slot; the next write lands one past it.
  assign wrSlot = bump(wrPtr);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.push && wrSlot == PTR_W'(gi)) store[gi] <= {wrTag, wrData};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= PTR_W'(DEPTH - 1);
      rdPtr  <= '0;
      rdData <= '0;
      rdTag  <= '0;
    end else if (strobe.flush) begin
      wrPtr <= PTR_W'(DEPTH - 1);
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrSlot;
      if (strobe.pop) begin
        {rdTag, rdData} <= store[rdPtr];
        rdPtr <= bump(rdPtr);
      end
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pop |=> $stable({rdTag, rdData})); // R4

endmodule

// File: rtl/scan_batch_fifo.sv
module scan_batch_fifo
  import sbf_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int TAG_W  = 2,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [TAG_W-1:0]  rdTag,
  input  logic [2:0]        cfgLevel,
  input  logic [TAG_W-1:0]  cfgChans,
  input  logic              cfgFlush,
  output logic              dataAvail,
  output logic              overflow,
  output logic              underflow
);

  fifoStrobe_t      strobe;
  logic [CNT_W-1:0] countQ;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  sbf_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrTag(wrTag), .rdEn(rdEn),
    .cfgLevel(cfgLevel), .cfgChans(cfgChans), .cfgFlush(cfgFlush),
    .strobe(strobe), .countQ(countQ), .dataAvail(dataAvail),
    .overflow(overflow), .underflow(underflow)
  );

  sbf_datapath #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .wrTag(wrTag),
    .rdData(rdData), .rdTag(rdTag), .wrPtr(wrPtr), .rdPtr(rdPtr)
  );

  // Pointer distance and unread count are kept by different modules.
  AST_PTR_COUNT_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    ((int'(wrPtr) + 1 - int'(rdPtr) + DEPTH) % DEPTH) == (int'(countQ) % DEPTH)); // R2

endmodule

// File: tb/scan_batch_fifo_bench.sv
module scan_batch_fifo_bench;
  localparam int PERIOD = 10;

  logic clk = 0;
  logic rstN = 0;
  logic wrEn = 0, rdEn = 0, cfgFlush = 0;
  logic [9:0] wrData = '0;
  logic [1:0] wrTag = '0, cfgChans = '0;
  logic [2:0] cfgLevel = '0;
  logic [9:0] rdData;
  logic [1:0] rdTag;
  logic dataAvail, overflow, underflow;

  int compared = 0;
  int mismatched = 0;

  // Reference state derived from the requirements.
  logic [11:0] mMem [16];
  int mCnt = 0, mRd = 0, mWr = 15, mScan = 0;
  logic mOv = 0, mUn = 0;
  logic [9:0] mData = '0;
  logic [1:0] mTag = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #(PERIOD/2) clk = ~clk;

  scan_batch_fifo u_scan_batch_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrTag(wrTag),
    .rdEn(rdEn), .rdData(rdData), .rdTag(rdTag), .cfgLevel(cfgLevel),
    .cfgChans(cfgChans), .cfgFlush(cfgFlush), .dataAvail(dataAvail),
    .overflow(overflow), .underflow(underflow)
  );

  function automatic int lvl(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 12;
      default: return 16;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll(input bit popped);
    check(popped ? "R2 rdData" : "R4 rdData held", int'(rdData), int'(mData));
    check(popped ? "R2 rdTag" : "R4 rdTag held", int'(rdTag), int'(mTag));
    check("R5 R6 dataAvail", int'(dataAvail), int'(mCnt >= lvl(cfgLevel)));
    check("R3 overflow", int'(overflow), int'(mOv));
    check("R4 underflow", int'(underflow), int'(mUn));
  endtask

  task automatic cycle(input logic w, input logic [1:0] t, input logic [9:0] d,
                       input logic r, input logic f);
    bit doR, doW;
    @(negedge clk);
    wrEn = w; wrTag = t; wrData = d; rdEn = r; cfgFlush = f;
    doR = 0;
    if (f) begin
      mCnt = 0; mRd = 0; mWr = 15; mScan = 0; mOv = 0; mUn = 0;  // R8
    end else begin
      doW = w && (int'(t) == mScan) && (mCnt < 16);
      if (w && int'(t) == mScan && mCnt == 16) mOv = 1;
      doR = r && (mCnt > 0);
      if (r && mCnt == 0) mUn = 1;
      if (doR) begin
        {mTag, mData} = mMem[mRd];
        mRd = (mRd + 1) % 16;
        mCnt--;
      end
      if (doW) begin
        mWr = (mWr + 1) % 16;
        mMem[mWr] = {t, d};
        mScan = (mScan == int'(cfgChans)) ? 0 : mScan + 1;  // R7
        mCnt++;
      end
    end
    @(posedge clk);
    #(PERIOD/4);
    wrEn = 0; rdEn = 0; cfgFlush = 0;
    compareAll(doR);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    // R1: reset state
    check("R1 dataAvail", int'(dataAvail), 0);
    check("R1 overflow", int'(overflow), 0);
    check("R1 underflow", int'(underflow), 0);
    check("R1 rdData", int'(rdData), 0);
    rstN = 1;
    cycle(1'b0, 2'd0, 10'd0, 1'b0, 1'b0);

    // Sweep every channel count and level code: fill, overflow, drain, underflow.
    for (int ch = 0; ch < 4; ch++) begin
      for (int code = 0; code < 8; code++) begin
        cfgChans = 2'(ch);
        cfgLevel = 3'(code);
        cycle(1'b0, 2'd0, 10'd0, 1'b0, 1'b1);
        for (int i = 0; i < 17; i++) begin
          if (i == 2) cycle(1'b1, 2'(mScan + 1), 10'h3FF, 1'b0, 1'b0);  // R7 wrong tag
          cycle(1'b1, 2'(mScan), 10'((ch * 97 + code * 31 + i * 13) & 10'h3FF), 1'b0, 1'b0);
        end
        for (int i = 0; i < 17; i++) cycle(1'b0, 2'd0, 10'd0, 1'b1, 1'b0);
      end
    end

    // R5: level change with a fixed unread count of 5.
    cfgChans = 2'd0;
    cycle(1'b0, 2'd0, 10'd0, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) cycle(1'b1, 2'd0, 10'(100 + i), 1'b0, 1'b0);
    for (int code = 0; code < 8; code++) begin
      cfgLevel = 3'(code);
      cycle(1'b0, 2'd0, 10'd0, 1'b0, 1'b0);
    end

    // R8: flush beats a same-cycle write and read; next expected channel is 0.
    cfgChans = 2'd2;
    cfgLevel = 3'd0;
    cycle(1'b1, 2'd0, 10'd77, 1'b1, 1'b1);
    cycle(1'b1, 2'd1, 10'd78, 1'b0, 1'b0);
    cycle(1'b1, 2'd0, 10'd79, 1'b0, 1'b0);
    cycle(1'b0, 2'd0, 10'd0, 1'b1, 1'b0);
    cycle(1'b0, 2'd0, 10'd0, 1'b1, 1'b0);

    // R2 R6: long mixed traffic with pointer wrap, occasional wrong tags and flushes.
    cfgChans = 2'd1;
    cfgLevel = 3'd3;
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[0] | lfsr[5], (lfsr[7:3] == 5'd0) ? 2'(mScan + 1) : 2'(mScan),
            lfsr[15:6], lfsr[1] & ~lfsr[9], lfsr[14:4] == 11'd0);
    end

    summary();
    $finish;
  end

endmodule